// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer whose down-counter runs from its own slow clock, so it keeps running even when the main system clock stops. Software reaches it through a single write port on the bus clock. A selector picks the key register, the divisor register or the reload register. Writing 16-bit magic codes to the key register does three things: it starts the watchdog, it reloads the counter from the reload register, and it opens the two setting registers for one change. Any other key value closes them again.

The 12-bit counter decrements once every prescaled slow-clock period. When a prescaled tick finds the counter at zero, the block raises a one-cycle reset pulse in the slow domain for the system reset controller. Writes to the divisor and reload registers are carried into the slow domain by a toggle handshake. A busy flag for each register stays high until its handshake has completed. A strap input starts the timer at power-on without a key. A debug-halt input combined with a stop-enable bit freezes the count.

Top module: `key_watchdog`

## Requirements
- R1: After reset, `wd_count` is 0xFFF, `wd_active`, `wd_reset`, `div_busy` and `rld_busy` are 0, and the count holds still until the watchdog is started.
- R2: A key write (`wr_sel`=0) of 0xCCCC sets `wd_active`. The count starts from 0xFFF. No later key write clears `wd_active`; only `rst_n` does.
- R3: With `hw_strap`=1 the watchdog becomes active after reset without any key write, and it counts from 0xFFF.
- R4: The divisor field (`wr_data[2:0]`, value p) sets the tick period to 2^(2+p) `lclk` cycles, capped at 256 for p≥6. `wd_count` falls by exactly one per tick.
- R5: A key write of 0xAAAA, while active, loads the reload value into the count and restarts the tick phase. Apart from that load, the count changes only by a decrement of one.
- R6: A tick that finds the count at 0 drives `wd_reset` high for exactly one `lclk` cycle. The count stays 0 and a further pulse follows on each later tick. With a reload of 3, the first pulse comes 4 tick periods after the load.
- R7: Writes to the divisor (`wr_sel`=1) and reload (`wr_sel`=2, `wr_data[11:0]`) registers are accepted only after a key write of 0x5555. A key write of any other value, including 0xAAAA and 0xCCCC, locks them again. A locked write has no effect and raises no busy flag.
- R8: An accepted setting write raises its busy flag on the next `clk` cycle. The flag drops once the value has reached the `lclk` domain. A write to a register whose flag is high is ignored.
- R9: With `dbg_halt` and `dbg_freeze_en` both 1, the count and the tick phase hold. Either input alone leaves counting unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Target: 0 key, 1 divisor, 2 reload |
| wr_data | input | 16 | Write data |
| div_busy | output | 1 | Divisor update in flight to the slow domain |
| rld_busy | output | 1 | Reload update in flight to the slow domain |
| lclk | input | 1 | Dedicated low-speed watchdog clock |
| hw_strap | input | 1 | Start at power-on without a key |
| dbg_halt | input | 1 | Core halted for debug |
| dbg_freeze_en | input | 1 | Allow debug halt to freeze the counter |
| wd_count | output | 12 | Current down-counter value |
| wd_active | output | 1 | Watchdog running |
| wd_reset | output | 1 | One-cycle expiry pulse in the `lclk` domain |

## Verification
The hardest situation to reach is one where exact tick timing and the lock rules must be seen through a counter that never stops once started. The stimulus holds the count still with the debug freeze while it rewrites the settings and issues reloads. This lets each reload value be read back exactly. Releasing the freeze on a known slow-clock edge then lets the bench count cycles to the first decrement and to the expiry pulse for every divisor code. The same freeze keeps each protection test, and each write made while busy, observable as a plain count value after a reload.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
    localparam int KEY_W = 16;
    localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_RELOAD = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;

    typedef enum logic [1:0] {
        SEL_KEY    = 2'd0,
        SEL_DIV    = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_NONE   = 2'd3
    } wdg_sel_e;
endpackage

// File: rtl/wdg_sync.sv
`timescale 1ns/1ps
module wdg_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/wdg_bus_regs.sv
`timescale 1ns/1ps
module wdg_bus_regs
    import wdg_pkg::*;
#(
    parameter int PR_W  = 3,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [KEY_W-1:0] wr_data,
    input  logic             pr_ack,
    input  logic             rl_ack,
    output logic             start_lvl,
    output logic             ld_tgl,
    output logic             pr_req,
    output logic             rl_req,
    output logic [PR_W-1:0]  pr_shadow,
    output logic [CNT_W-1:0] rl_shadow,
    output logic             pr_busy,
    output logic             rl_busy,
    output logic             unlock
);
    typedef struct packed {
        logic             unlock;
        logic             start;
        logic             ld_tg;
        logic             pr_tg;
        logic             rl_tg;
        logic [PR_W-1:0]  pr;
        logic [CNT_W-1:0] rl;
    } regs_t;

    regs_t r_q, r_d;

    // a request is open while its toggle differs from the echoed one
    assign pr_busy = r_q.pr_tg ^ pr_ack;
    assign rl_busy = r_q.rl_tg ^ rl_ack;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wdg_sel_e'(wr_sel))
                SEL_KEY: begin
                    r_d.unlock = (wr_data == KEY_UNLOCK);
                    if (wr_data == KEY_START)  r_d.start = 1'b1;
                    if (wr_data == KEY_RELOAD) r_d.ld_tg = ~r_q.ld_tg;
                end
                SEL_DIV: begin
                    if (r_q.unlock && !pr_busy) begin
                        r_d.pr    = wr_data[PR_W-1:0];
                        r_d.pr_tg = ~r_q.pr_tg;
                    end
                end
                SEL_RELOAD: begin
                    if (r_q.unlock && !rl_busy) begin
                        r_d.rl    = wr_data[CNT_W-1:0];
                        r_d.rl_tg = ~r_q.rl_tg;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{unlock: 1'b0, start: 1'b0, ld_tg: 1'b0, pr_tg: 1'b0,
                     rl_tg: 1'b0, pr: '0, rl: '1};
        end else begin
            r_q <= r_d;
        end
    end

    assign start_lvl = r_q.start;
    assign ld_tgl    = r_q.ld_tg;
    assign pr_req    = r_q.pr_tg;
    assign rl_req    = r_q.rl_tg;
    assign pr_shadow = r_q.pr;
    assign rl_shadow = r_q.rl;
    assign unlock    = r_q.unlock;
endmodule

// File: rtl/wdg_core.sv
`timescale 1ns/1ps
module wdg_core #(
    parameter int PR_W     = 3,
    parameter int CNT_W    = 12,
    parameter int MIN_LOG2 = 2,
    parameter int MAX_LOG2 = 8
) (
    input  logic             lclk,
    input  logic             rst_n,
    input  logic             start_s,
    input  logic             hw_strap,
    input  logic             freeze,
    input  logic             pr_req_s,
    input  logic             rl_req_s,
    input  logic             ld_s,
    input  logic [PR_W-1:0]  pr_shadow,
    input  logic [CNT_W-1:0] rl_shadow,
    output logic             pr_ack,
    output logic             rl_ack,
    output logic             ld_evt,
    output logic [CNT_W-1:0] count,
    output logic             active,
    output logic             expire
);
    localparam int PS_W = MAX_LOG2;

    typedef struct packed {
        logic             active;
        logic             expire;
        logic             pr_tg;
        logic             rl_tg;
        logic             ld_tg;
        logic [PR_W-1:0]  pr;
        logic [CNT_W-1:0] rl;
        logic [PS_W-1:0]  presc;
        logic [CNT_W-1:0] cnt;
    } core_t;

    core_t c_q, c_d;

    function automatic logic [PS_W-1:0] div_last(input logic [PR_W-1:0] p);
        int unsigned sh;
        logic [PS_W:0] full;
        sh = MIN_LOG2 + int'(p);
        if (sh > MAX_LOG2) sh = MAX_LOG2;
        full = (PS_W+1)'(1) << sh;
        return PS_W'(full - 1'b1);
    endfunction

    assign ld_evt = (ld_s != c_q.ld_tg);

    always_comb begin
        c_d        = c_q;
        c_d.expire = 1'b0;
        c_d.ld_tg  = ld_s;
        // shadow values are stable while their toggle is outstanding
        if (pr_req_s != c_q.pr_tg) begin
            c_d.pr    = pr_shadow;
            c_d.pr_tg = pr_req_s;
        end
        if (rl_req_s != c_q.rl_tg) begin
            c_d.rl    = rl_shadow;
            c_d.rl_tg = rl_req_s;
        end
        if (!c_q.active) begin
            if (start_s || hw_strap) begin
                c_d.active = 1'b1;
                c_d.cnt    = '1;
                c_d.presc  = '0;
            end
        end else if (ld_evt) begin
            c_d.cnt   = c_q.rl;
            c_d.presc = '0;
        end else if (!freeze) begin
            if (c_q.presc >= div_last(c_q.pr)) begin
                c_d.presc = '0;
                if (c_q.cnt == '0) c_d.expire = 1'b1;
                else               c_d.cnt    = c_q.cnt - 1'b1;
            end else begin
                c_d.presc = c_q.presc + 1'b1;
            end
        end
    end

    always_ff @(posedge lclk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{active: 1'b0, expire: 1'b0, pr_tg: 1'b0, rl_tg: 1'b0,
                     ld_tg: 1'b0, pr: '0, rl: '1, presc: '0, cnt: '1};
        end else begin
            c_q <= c_d;
        end
    end

    assign pr_ack = c_q.pr_tg;
    assign rl_ack = c_q.rl_tg;
    assign count  = c_q.cnt;
    assign active = c_q.active;
    assign expire = c_q.expire;
endmodule

// File: rtl/key_watchdog.sv
`timescale 1ns/1ps
module key_watchdog
    import wdg_pkg::*;
#(
    parameter int PR_W     = 3,
    parameter int CNT_W    = 12,
    parameter int MIN_LOG2 = 2,
    parameter int MAX_LOG2 = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [15:0]      wr_data,
    output logic             div_busy,
    output logic             rld_busy,
    input  logic             lclk,
    input  logic             hw_strap,
    input  logic             dbg_halt,
    input  logic             dbg_freeze_en,
    output logic [CNT_W-1:0] wd_count,
    output logic             wd_active,
    output logic             wd_reset
);
    logic             start_lvl, ld_tgl, pr_req, rl_req;
    logic [PR_W-1:0]  pr_shadow;
    logic [CNT_W-1:0] rl_shadow;
    logic             pr_ack, rl_ack;
    logic [1:0]       ack_s;
    logic [3:0]       req_s;
    logic             unlock_w, ld_evt_w, freeze_w;

    assign freeze_w = dbg_halt & dbg_freeze_en;

    wdg_bus_regs #(.PR_W(PR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pr_ack(ack_s[0]), .rl_ack(ack_s[1]),
        .start_lvl(start_lvl), .ld_tgl(ld_tgl), .pr_req(pr_req),
        .rl_req(rl_req), .pr_shadow(pr_shadow), .rl_shadow(rl_shadow),
        .pr_busy(div_busy), .rl_busy(rld_busy), .unlock(unlock_w)
    );

    wdg_sync #(.W(4)) u_to_slow (
        .clk(lclk), .rst_n(rst_n),
        .d({rl_req, pr_req, ld_tgl, start_lvl}), .q(req_s)
    );

    wdg_sync #(.W(2)) u_to_bus (
        .clk(clk), .rst_n(rst_n), .d({rl_ack, pr_ack}), .q(ack_s)
    );

    wdg_core #(.PR_W(PR_W), .CNT_W(CNT_W), .MIN_LOG2(MIN_LOG2),
               .MAX_LOG2(MAX_LOG2)) u_core (
        .lclk(lclk), .rst_n(rst_n), .start_s(req_s[0]), .hw_strap(hw_strap),
        .freeze(freeze_w), .pr_req_s(req_s[2]), .rl_req_s(req_s[3]),
        .ld_s(req_s[1]), .pr_shadow(pr_shadow), .rl_shadow(rl_shadow),
        .pr_ack(pr_ack), .rl_ack(rl_ack), .ld_evt(ld_evt_w),
        .count(wd_count), .active(wd_active), .expire(wd_reset)
    );
endmodule

// File: rtl/wdg_checker.sv
`timescale 1ns/1ps
module wdg_checker
    import wdg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             lclk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [15:0]      wr_data,
    input logic             div_busy,
    input logic             unlock,
    input logic             ld_evt,
    input logic             freeze,
    input logic [CNT_W-1:0] wd_count,
    input logic             wd_active,
    input logic             wd_reset
);
    assert_never_stops_R2: assert property (@(posedge lclk) disable iff (!rst_n)
        !$fell(wd_active));

    assert_step_by_one_R5: assert property (@(posedge lclk) disable iff (!rst_n)
        !ld_evt |=> (wd_count == $past(wd_count) || wd_count == $past(wd_count) - 1'b1));

    assert_pulse_at_zero_R6: assert property (@(posedge lclk) disable iff (!rst_n)
        wd_reset |-> (wd_count == '0));

    assert_pulse_single_R6: assert property (@(posedge lclk) disable iff (!rst_n)
        wd_reset |=> !wd_reset);

    assert_freeze_holds_R9: assert property (@(posedge lclk) disable iff (!rst_n)
        (freeze && wd_active && !ld_evt) |=> $stable(wd_count));

    assert_other_key_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_KEY && wr_data != KEY_UNLOCK) |=> !unlock);

    assert_locked_write_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_DIV && !unlock && !div_busy) |=> !div_busy);
endmodule

bind key_watchdog wdg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .lclk(lclk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .div_busy(div_busy), .unlock(unlock_w),
    .ld_evt(ld_evt_w), .freeze(freeze_w), .wd_count(wd_count),
    .wd_active(wd_active), .wd_reset(wd_reset)
);

// File: tb/key_watchdog_tb.sv
`timescale 1ns/1ps
module key_watchdog_tb;
    logic        clk = 1'b0, lclk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic        hw_strap = 1'b0, dbg_halt = 1'b0, dbg_freeze_en = 1'b0;
    logic        div_busy, rld_busy, wd_active, wd_reset;
    logic [11:0] wd_count;
    int          compared = 0, mismatched = 0;
    bit          done = 1'b0;

    always #2  clk  = ~clk;
    always #12 lclk = ~lclk;

    key_watchdog u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .div_busy(div_busy), .rld_busy(rld_busy),
        .lclk(lclk), .hw_strap(hw_strap), .dbg_halt(dbg_halt),
        .dbg_freeze_en(dbg_freeze_en), .wd_count(wd_count),
        .wd_active(wd_active), .wd_reset(wd_reset)
    );

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && (div_busy || rld_busy); i++) @(negedge clk);
    endtask

    task automatic set_freeze(input logic h, input logic e);
        @(negedge lclk);
        dbg_halt = h; dbg_freeze_en = e;
    endtask

    // reload while frozen, then read the count back exactly
    task automatic reload_read(input string req, input int exp);
        bus_wr(2'd0, 16'hAAAA);
        repeat (8) @(negedge lclk);
        chk(req, int'(wd_count), exp);
    endtask

    task automatic run_period(input int p);
        int div, n;
        div = 1 << ((2 + p) > 8 ? 8 : (2 + p));
        set_freeze(1'b1, 1'b1);
        bus_wr(2'd0, 16'h5555);
        bus_wr(2'd1, 16'(p));
        chk("R8 divisor busy raised", int'(div_busy), 1);
        wait_idle();
        chk("R8 divisor busy cleared", int'(div_busy), 0);
        bus_wr(2'd0, 16'h5555);
        bus_wr(2'd2, 16'h0003);
        wait_idle();
        reload_read("R5 reload value loaded", 3);
        set_freeze(1'b0, 1'b1);
        n = 0;
        while (wd_count == 12'd3 && n < 2000) begin @(negedge lclk); n++; end
        chk("R4 tick period", n, div);
        chk("R4 decrement by one", int'(wd_count), 2);
        while (!wd_reset && n < 2000) begin @(negedge lclk); n++; end
        chk("R6 expiry time", n, 4 * div);
        chk("R6 count at zero", int'(wd_count), 0);
        @(negedge lclk);
        chk("R6 pulse width", int'(wd_reset), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL all: watchdog expired, actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int n, c;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge lclk);
        // R1: reset state and idle hold
        chk("R1 count", int'(wd_count), 12'hFFF);
        chk("R1 active", int'(wd_active), 0);
        chk("R1 reset out", int'(wd_reset), 0);
        chk("R1 busy", int'({div_busy, rld_busy}), 0);
        repeat (20) @(negedge lclk);
        chk("R1 holds before start", int'(wd_count), 12'hFFF);

        // R2: start key
        bus_wr(2'd0, 16'hCCCC);
        for (int i = 0; i < 20 && !wd_active; i++) @(negedge lclk);
        chk("R2 started", int'(wd_active), 1);
        chk("R2 count from max", int'(wd_count), 12'hFFF);
        n = 0;
        while (wd_count == 12'hFFF && n < 100) begin @(negedge lclk); n++; end
        chk("R2 first tick default divisor", n, 4);
        chk("R2 first decrement", int'(wd_count), 12'hFFE);

        // R2: other keys cannot stop it
        bus_wr(2'd0, 16'h0000);
        bus_wr(2'd0, 16'hFFFF);
        bus_wr(2'd0, 16'h1234);
        repeat (6) @(negedge lclk);
        chk("R2 not stoppable", int'(wd_active), 1);

        // R4/R6: sweep all divisor codes
        for (int p = 0; p < 8; p++) run_period(p);

        // R9: freeze combinations at the shortest divisor
        set_freeze(1'b1, 1'b1);
        bus_wr(2'd0, 16'h5555); bus_wr(2'd1, 16'h0000); wait_idle();
        bus_wr(2'd0, 16'h5555); bus_wr(2'd2, 16'h0FFF); wait_idle();
        reload_read("R5 reload max", 12'hFFF);
        c = int'(wd_count);
        repeat (40) @(negedge lclk);
        chk("R9 frozen holds", int'(wd_count), c);
        set_freeze(1'b1, 1'b0);
        c = int'(wd_count);
        repeat (12) @(negedge lclk);
        chk("R9 halt alone counts", int'(wd_count != 12'(c)), 1);
        set_freeze(1'b0, 1'b1);
        c = int'(wd_count);
        repeat (12) @(negedge lclk);
        chk("R9 enable alone counts", int'(wd_count != 12'(c)), 1);

        // R7: protection sequence
        set_freeze(1'b1, 1'b1);
        bus_wr(2'd2, 16'h0123);
        chk("R7 locked reload no busy", int'(rld_busy), 0);
        bus_wr(2'd1, 16'h0005);
        chk("R7 locked divisor no busy", int'(div_busy), 0);
        reload_read("R7 locked write ignored", 12'hFFF);
        bus_wr(2'd0, 16'h5555); bus_wr(2'd0, 16'h1234); bus_wr(2'd2, 16'h0123);
        chk("R7 junk key relocks", int'(rld_busy), 0);
        bus_wr(2'd0, 16'h5555); bus_wr(2'd0, 16'hAAAA); bus_wr(2'd2, 16'h0123);
        chk("R7 reload key relocks", int'(rld_busy), 0);
        bus_wr(2'd0, 16'h5555); bus_wr(2'd0, 16'hCCCC); bus_wr(2'd2, 16'h0123);
        chk("R7 start key relocks", int'(rld_busy), 0);
        reload_read("R7 value unchanged", 12'hFFF);
        bus_wr(2'd0, 16'h5555); bus_wr(2'd2, 16'h0123);
        chk("R7 unlocked write accepted", int'(rld_busy), 1);
        wait_idle();
        reload_read("R7 new reload value", 12'h123);

        // R8: write while busy is dropped
        bus_wr(2'd0, 16'h5555);
        bus_wr(2'd2, 16'h0005);
        bus_wr(2'd2, 16'h0009);
        wait_idle();
        reload_read("R8 write while busy ignored", 5);

        // R3: hardware strap
        @(negedge clk);
        rst_n = 1'b0; hw_strap = 1'b1; dbg_halt = 1'b0; dbg_freeze_en = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 20 && !wd_active; i++) @(negedge lclk);
        chk("R3 strap starts", int'(wd_active), 1);
        chk("R3 count from max", int'(wd_count), 12'hFFF);
        n = 0;
        while (wd_count == 12'hFFF && n < 100) begin @(negedge lclk); n++; end
        chk("R3 counting", int'(wd_count), 12'hFFE);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule